// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 28-bit physical address by reading a two-level page table held in memory. Each request carries a virtual address, an access kind (read, write or execute), a user/kernel flag and the physical base of the first-level table. The walker reads the first-level entry, follows it to a second-level table, reads the leaf entry, and then checks the leaf's permission bits before it reports a result.

The split is uneven. The top 8 address bits select one of 256 first-level entries, the next 11 bits select one of 2048 leaf entries, and the low 13 bits pass through as the offset into an 8 KB page. Memory is reached over a single-word request/response port, with at most one read outstanding. The result appears as a one-cycle done pulse. With it comes either a physical address or a fault code that tells a missing mapping apart from a permission violation.

Top module: `pt_walker`

## Requirements
- R1: After reset, ready_o is 1, and done_o and mem_req_o are 0.
- R2: A request seen while ready_o is 1 raises mem_req_o for exactly one cycle in the next cycle. The address is root base + vaddr[31:24]*4.
- R3: The second read goes to {first-level PPN, 13'b0} + vaddr[23:13]*4, so two addresses with equal bits [31:24] read from the same second-level table.
- R4: Entries use bit 0 valid, bit 1 readable, bit 2 writable, bit 3 executable, bit 4 kernel-only and bits [27:13] PPN, at both levels.
- R5: A walk with no fault returns paddr_o = {leaf PPN, vaddr[12:0]}.
- R6: An invalid first-level entry ends the walk with fault code 1 (page) and issues no second read.
- R7: An invalid leaf gives fault code 1 even when its permission or kernel bits would also fail.
- R8: A valid leaf gives fault code 2 (protection) when the access kind (0 read, 1 write, 2 execute) lacks its permission bit, or when req_user_i is 1 and the kernel-only bit is set. Otherwise the code is 0.
- R9: done_o is high for one cycle, in the cycle after the final read response, and paddr_o is 0 whenever the fault code is not 0.
- R10: req_valid_i has no effect while ready_o is 0. No extra reads occur, and the result belongs to the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user_i | input | 1 | 1 for a user-mode access |
| root_base_i | input | 28 | Physical base of the first-level table |
| ready_o | output | 1 | Walker idle, request accepted |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 28 | Read address of the entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 2 | 0 none, 1 page, 2 protection |
| paddr_o | output | 28 | Physical address, 0 on fault |

## Verification
The bench goes after fault ordering: a leaf that is invalid yet carries kernel and write bits must report a page fault, so a design that checks permissions first would return code 2. A missing first-level entry must stop after one read, and a walker that always goes on to the second level shows up as an extra memory request. Requests that arrive mid-walk are a further target, since a walker that accepts them would issue stray reads or return the wrong address. Leaf indices at 0 and 2047, offset 0x1FFF and memory latencies of one and three cycles check the address arithmetic and the pulse timing.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int PTE_V_BIT   = 0;
  localparam int PTE_R_BIT   = 1;
  localparam int PTE_W_BIT   = 2;
  localparam int PTE_X_BIT   = 3;
  localparam int PTE_K_BIT   = 4;
  localparam int PTE_PPN_LSB = 13;
  localparam int ENTRY_SHIFT = 2;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_PAGE = 2'd1, FLT_PROT = 2'd2} fault_e;
  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
  } walk_state_e;
endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int PA_W  = 28,
  parameter int IDX_W = 8
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  addr_o
);
  import pt_walker_pkg::*;
  logic [PA_W-1:0] idx_ext;
  always_comb begin
    idx_ext = PA_W'(idx_i);
    addr_o  = base_i + (idx_ext << ENTRY_SHIFT);
  end
endmodule

// File: rtl/pt_leaf_chk.sv
module pt_leaf_chk #(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  output logic [1:0]       fault_o
);
  import pt_walker_pkg::*;
  logic perm_ok;
  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  perm_ok = pte_i[PTE_R_BIT];
      ACC_WRITE: perm_ok = pte_i[PTE_W_BIT];
      ACC_EXEC:  perm_ok = pte_i[PTE_X_BIT];
      default:   perm_ok = 1'b0;
    endcase
    // presence wins over permission
    if (!pte_i[PTE_V_BIT])                          fault_o = FLT_PAGE;
    else if (!perm_ok || (user_i && pte_i[PTE_K_BIT])) fault_o = FLT_PROT;
    else                                            fault_o = FLT_NONE;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 28,
  parameter int OFF_W    = 13,
  parameter int L2_IDX_W = 11,
  parameter int PTE_W    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_acc_i,
  input  logic             req_user_i,
  input  logic [PA_W-1:0]  root_base_i,
  output logic             ready_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic [1:0]       fault_o,
  output logic [PA_W-1:0]  paddr_o
);
  import pt_walker_pkg::*;
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int L1_IDX_W = VA_W - OFF_W - L2_IDX_W;

  walk_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q;
  logic [PA_W-1:0]  root_q;
  logic [PPN_W-1:0] l2_ppn_q;
  logic [1:0]       fault_q;
  logic [PA_W-1:0]  paddr_q;
  logic [PA_W-1:0]  l1_addr, l2_addr, l2_base;
  logic [1:0]       leaf_fault;
  logic [PPN_W-1:0] rd_ppn;

  assign l2_base = {l2_ppn_q, {OFF_W{1'b0}}};
  assign rd_ppn  = mem_rdata_i[PTE_PPN_LSB +: PPN_W];

  pt_entry_addr #(.PA_W(PA_W), .IDX_W(L1_IDX_W)) u_l1_addr (
    .base_i(root_q), .idx_i(va_q[VA_W-1 -: L1_IDX_W]), .addr_o(l1_addr));

  pt_entry_addr #(.PA_W(PA_W), .IDX_W(L2_IDX_W)) u_l2_addr (
    .base_i(l2_base), .idx_i(va_q[OFF_W +: L2_IDX_W]), .addr_o(l2_addr));

  pt_leaf_chk #(.PTE_W(PTE_W)) u_leaf_chk (
    .pte_i(mem_rdata_i), .acc_i(acc_q), .user_i(user_q), .fault_o(leaf_fault));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      va_q     <= '0;
      acc_q    <= '0;
      user_q   <= 1'b0;
      root_q   <= '0;
      l2_ppn_q <= '0;
      fault_q  <= FLT_NONE;
      paddr_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          acc_q   <= req_acc_i;
          user_q  <= req_user_i;
          root_q  <= root_base_i;
          state_q <= S_L1_REQ;
        end
        S_L1_REQ: state_q <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rvalid_i) begin
          if (!mem_rdata_i[PTE_V_BIT]) begin
            fault_q <= FLT_PAGE;
            paddr_q <= '0;
            state_q <= S_DONE;
          end else begin
            l2_ppn_q <= rd_ppn;
            state_q  <= S_L2_REQ;
          end
        end
        S_L2_REQ: state_q <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rvalid_i) begin
          fault_q <= leaf_fault;
          paddr_q <= (leaf_fault == FLT_NONE) ? {rd_ppn, va_q[OFF_W-1:0]} : '0;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o    = (state_q == S_IDLE);
  assign mem_req_o  = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
  assign mem_addr_o = (state_q == S_L2_REQ || state_q == S_L2_WAIT) ? l2_addr : l1_addr;
  assign done_o     = (state_q == S_DONE);
  assign fault_o    = fault_q;
  assign paddr_o    = paddr_q;

  // R2
  accept_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && req_valid_i |=> mem_req_o && !ready_o);
  // R2
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && ready_o);
  // R9
  done_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rvalid_i));
  // R9
  fault_paddr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o != 2'd0 |-> paddr_o == '0);
  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && !done_o |=> $stable(va_q));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic [27:0] root_base = 28'h0010000;
  logic        ready, mem_req, mem_rvalid, done;
  logic [27:0] mem_addr, paddr;
  logic [31:0] mem_rdata;
  logic [1:0]  fault;

  int tests = 0, fails = 0, lat = 1, done_cnt = 0;
  logic [1:0]  got_fault;
  logic [27:0] got_paddr;
  logic [27:0] reqs_q[$];
  logic        rv_d = 1'b0;
  logic [31:0] mem [logic [27:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_acc_i(req_acc), .req_user_i(req_user), .root_base_i(root_base),
    .ready_o(ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .paddr_o(paddr));

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte(input logic [14:0] ppn, input logic [4:0] fl);
    return {4'b0, ppn, 8'b0, fl};
  endfunction
  function automatic logic [31:0] mk_va(input int i1, input int i2, input int off);
    return (32'(i1) << 24) | (32'(i2) << 13) | 32'(off);
  endfunction
  function automatic logic [31:0] rd(input logic [27:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [27:0] a;
        a = mem_addr;
        repeat (lat) @(negedge clk);
        mem_rdata  = rd(a);
        mem_rvalid = 1'b1;
      end
    end
  end

  always @(posedge clk) rv_d <= mem_rvalid;

  always @(negedge clk) if (rst_n) begin
    if (mem_req) reqs_q.push_back(mem_addr);
    if (done) begin
      done_cnt++;
      got_fault = fault;
      got_paddr = paddr;
      check(rv_d, "R9", "done without preceding response", 32'(rv_d), 32'd1);
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                      input bit spur, input string tag);
    logic [31:0] e1, e2;
    logic [27:0] a1, a2, ep;
    logic [1:0]  ef;
    int          nr;
    logic        perm;
    // reference translation
    a1 = root_base + 28'(va[31:24]) * 4;
    e1 = rd(a1);
    a2 = '0; ep = '0; nr = 1;
    if (!e1[0]) ef = 2'd1;
    else begin
      nr = 2;
      a2 = {e1[27:13], 13'b0} + 28'(va[23:13]) * 4;
      e2 = rd(a2);
      perm = (acc == 2'd0) ? e2[1] : (acc == 2'd1) ? e2[2] : (acc == 2'd2) ? e2[3] : 1'b0;
      if (!e2[0]) ef = 2'd1;
      else if (!perm || (usr && e2[4])) ef = 2'd2;
      else begin ef = 2'd0; ep = {e2[27:13], va[12:0]}; end
    end
    reqs_q.delete();
    done_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    if (spur) begin
      req_valid = 1'b1; req_vaddr = ~va; req_acc = 2'd0; req_user = 1'b0;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(done_cnt == 1, "R9", {tag, " done count"}, 32'(done_cnt), 32'd1);
    check(got_fault == ef, ef == 2'd2 ? "R8" : (ef == 2'd1 ? "R7" : "R8"),
          {tag, " fault"}, 32'(got_fault), 32'(ef));
    check(got_paddr == ep, ef == 2'd0 ? "R5" : "R9", {tag, " paddr"}, 32'(got_paddr), 32'(ep));
    check(reqs_q.size() == nr, spur ? "R10" : "R6", {tag, " read count"},
          32'(reqs_q.size()), 32'(nr));
    if (reqs_q.size() > 0)
      check(reqs_q[0] == a1, "R2", {tag, " L1 addr"}, 32'(reqs_q[0]), 32'(a1));
    if (nr == 2 && reqs_q.size() > 1)
      check(reqs_q[1] == a2, "R3", {tag, " L2 addr"}, 32'(reqs_q[1]), 32'(a2));
    check(ready == 1'b1, "R10", {tag, " ready after"}, 32'(ready), 32'd1);
  endtask

  initial begin
    // R4 layout: V=bit0 R=bit1 W=bit2 X=bit3 K=bit4, PPN [27:13]
    mem[root_base + 28'h12*4] = pte(15'h0040, 5'b00001);
    mem[root_base + 28'hFF*4] = pte(15'h0050, 5'b00001);
    mem[root_base + 28'h34*4] = pte(15'h0060, 5'b11110); // invalid L1
    mem[{15'h0040, 13'b0} + 28'h345*4] = pte(15'h1ABC, 5'b01111);
    mem[{15'h0040, 13'b0} + 28'h346*4] = pte(15'h0222, 5'b00011);
    mem[{15'h0040, 13'b0} + 28'h347*4] = pte(15'h0333, 5'b10111);
    mem[{15'h0040, 13'b0} + 28'h348*4] = pte(15'h0444, 5'b11110); // invalid leaf
    mem[{15'h0040, 13'b0} + 28'h7FF*4] = pte(15'h7FFF, 5'b01111);
    mem[{15'h0050, 13'b0}]             = pte(15'h0001, 5'b00011);

    repeat (3) @(negedge clk);
    // R1
    check(ready == 1'b1, "R1", "ready in reset", 32'(ready), 32'd1);
    check(done == 1'b0, "R1", "done in reset", 32'(done), 32'd0);
    check(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int l = 1; l <= 3; l += 2) begin
      lat = l;
      walk(mk_va(8'h12, 11'h345, 13'h0ABC), 2'd0, 1'b1, 1'b0, "R5 user read ok");
      walk(mk_va(8'h12, 11'h345, 13'h1FFF), 2'd2, 1'b0, 1'b0, "R5 exec max offset");
      walk(mk_va(8'h12, 11'h7FF, 13'h0000), 2'd1, 1'b1, 1'b0, "R3 top leaf index");
      walk(mk_va(8'hFF, 11'h000, 13'h0123), 2'd0, 1'b0, 1'b0, "R2 top L1 index");
      walk(mk_va(8'h12, 11'h346, 13'h0010), 2'd1, 1'b0, 1'b0, "R8 write no W");
      walk(mk_va(8'h12, 11'h346, 13'h0010), 2'd2, 1'b0, 1'b0, "R8 exec no X");
      walk(mk_va(8'h12, 11'h347, 13'h0020), 2'd0, 1'b1, 1'b0, "R8 user kernel page");
      walk(mk_va(8'h12, 11'h347, 13'h0020), 2'd1, 1'b0, 1'b0, "R8 kernel on kernel page");
      walk(mk_va(8'h12, 11'h348, 13'h0030), 2'd1, 1'b1, 1'b0, "R7 invalid leaf");
      walk(mk_va(8'h12, 11'h400, 13'h0030), 2'd0, 1'b0, 1'b0, "R7 absent leaf");
      walk(mk_va(8'h34, 11'h345, 13'h0000), 2'd0, 1'b0, 1'b0, "R6 invalid L1");
      walk(mk_va(8'h12, 11'h345, 13'h0001), 2'd0, 1'b0, 1'b1, "R10 busy requests");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule